// File: doc/BRIEF.md
# Byte-serial parallel bus transmitter with ready/valid handshake

This block moves data from a host onto an 8-bit parallel bus that a receiver samples with a shared data clock. The host writes 32-bit words into a small word FIFO. Each word is split into four bytes, and the least-significant byte goes out first. At most one byte leaves per clock cycle. A data-enable output tells the receiver whether the byte on the bus is a new, valid transfer. A ready input from the receiver stalls the transmitter: the byte on the bus stays in place, with data-enable still active, until the receiver takes it.

The bus and data-enable change on the drive edge of the data clock. The ready input is captured on the opposite edge, half a cycle earlier, so it can steer the next drive edge. Consider a stall that arrives in the last one or two cycles before the FIFO runs dry. The held byte is still delivered with data-enable active. After that, data-enable drops while the bus keeps the last delivered byte, so no undelivered byte is ever left exposed with data-enable inactive.

The active levels of ready and data-enable are chosen by two static configuration inputs. A parameter selects which clock edge drives the bus. The host port runs on the same clock and has no handshake. A space flag says whether another word fits, and a sticky flag records any write that arrived while the FIFO was full.

Top module: `par_sync_tx`

## Requirements
- R1: While reset is held, `bus_data` is 0, `bus_de` shows the inactive level, `wr_space` is 1 and `ovf_flag` is 0.
- R2: Every byte of every accepted word is delivered exactly once, in write order, and within a word bit 7:0 goes first, then 15:8, 23:16 and 31:24. A byte counts as delivered in a cycle where data-enable and ready are both active.
- R3: With ready continuously active, two words written on back-to-back cycles appear as eight consecutive data-enable-active cycles.
- R4: When ready is inactive during a data-enable-active cycle, the next cycle shows the same byte with data-enable still active.
- R5: When no byte is waiting, data-enable goes inactive and `bus_data` keeps its previous value.
- R6: `bus_data` never changes in a cycle where data-enable is inactive. A stall one or two cycles before the FIFO empties loses no byte.
- R7: `cfg_rdy_pol` = 0 means a low `rdy_in` is ready. `cfg_rdy_pol` = 1 means a high `rdy_in` is ready.
- R8: `cfg_de_pol` = 0 means a low `bus_de` marks a valid byte. `cfg_de_pol` = 1 means a high `bus_de` marks a valid byte.
- R9: The FIFO holds 8 words. `wr_space` is 1 exactly when one more word (four bytes) fits, and a write with `wr_space` = 1 is always accepted.
- R10: A write while `wr_space` is 0 is discarded and sets `ovf_flag`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Parallel data clock; also clocks the host port |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_word | input | 32 | Host write data, four bytes |
| wr_space | output | 1 | At least one word slot free |
| ovf_flag | output | 1 | Sticky: a write was discarded |
| cfg_rdy_pol | input | 1 | Active level of `rdy_in` |
| cfg_de_pol | input | 1 | Active level of `bus_de` |
| rdy_in | input | 1 | Receiver ready, captured on the non-drive edge |
| bus_data | output | 8 | Parallel data bus |
| bus_de | output | 1 | Data-enable for the byte on the bus |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8-bit bytes, an 8-word FIFO, and the bus driven on the rising edge. Because the FIFO is that shallow, a few cycles of held-off ready are enough to fill it, so space exhaustion and a discarded write are easy to reach. With one-word bursts, a swept single or double stall lands on every position around the underrun. Both configuration inputs are ports, so all four polarity combinations run in one build under random traffic.

// File: rtl/par_tx_pkg.sv
// Shared definitions for the parallel byte transmitter.
// Assumes: polarity settings are static while traffic flows.
package par_tx_pkg;

    // Polarity setting: which pin level counts as "active"
    typedef enum logic {
        POL_LOW_ACTIVE  = 1'b0,
        POL_HIGH_ACTIVE = 1'b1
    } pol_e;

    // Convert between pin level and internal active-high meaning (self-inverse)
    function automatic logic pol_map(input logic level, input logic pol);
        return (pol == POL_HIGH_ACTIVE) ? level : ~level;
    endfunction

endpackage

// File: rtl/ptx_word_fifo.sv
// Word FIFO for the host side of the transmitter.
// Does: stores whole host words, reports full/empty, discards writes
// when full and records that in a sticky overflow flag.
// Assumes: push and pop in the same clock domain; the head word is valid
// only while empty is low.
module ptx_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              push;
    logic              do_pop;

    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);
    assign push   = push_req && !full;
    assign do_pop = pop && !empty;
    assign head   = mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; no reset needed on data
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky record of a discarded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (push_req && full) begin
            ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/ptx_byte_unpack.sv
// Splits the FIFO head word into bytes, lowest byte first.
// Does: presents the current byte, advances a lane index on each take and
// signals the FIFO to drop the word after its last lane is taken.
// Assumes: byte_take is only asserted while byte_valid is high.
module ptx_byte_unpack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] head_word,
    input  logic              word_valid,
    input  logic              byte_take,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid,
    output logic              word_done
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [BYTE_W-1:0] lane [LANES];
    logic [IDX_W-1:0]  idx;
    logic              last_lane;

    // One slice per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = head_word[g*BYTE_W +: BYTE_W];
    end

    assign byte_valid = word_valid;
    assign byte_out   = lane[idx];
    assign last_lane  = (idx == IDX_W'(LANES - 1));
    assign word_done  = byte_take && last_lane;

    // Lane index: step on each take, wrap after the top lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (byte_take) begin
            idx <= last_lane ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/ptx_ready_sample.sv
// Captures the receiver ready pin on the non-drive clock edge.
// Does: maps the pin through its polarity setting and holds the result
// for the following drive edge.
// Assumes: rdy_pin meets setup/hold around the falling edge of clk.
module ptx_ready_sample
    import par_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_pin,
    input  logic pol,
    output logic rdy_ok
);
    // Mid-cycle capture of the receiver's ready state
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            rdy_ok <= 1'b0;
        end else begin
            rdy_ok <= pol_map(rdy_pin, pol);
        end
    end

endmodule

// File: rtl/ptx_out_stage.sv
// Output register and data-enable control.
// Does: the bus byte is replaced only when the current byte was taken by the
// receiver or the bus is idle. A stalled byte stays with data-enable on.
// When nothing is waiting, data-enable drops and the bus keeps its value,
// so no untaken byte is ever shown as invalid.
// Assumes: rdy_ok was captured half a cycle before this edge.
module ptx_out_stage
    import par_tx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rdy_ok,
    input  logic              de_pol,
    output logic              byte_take,
    output logic [BYTE_W-1:0] bus_q,
    output logic              de_v,
    output logic              bus_de
);
    logic slot_free;

    // Bus may accept a new byte: idle, or current byte consumed this cycle
    assign slot_free = !de_v || rdy_ok;
    assign byte_take = slot_free && byte_valid;
    assign bus_de    = pol_map(de_v, de_pol);

    // Bus byte and data-enable update on the drive edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            de_v  <= 1'b0;
        end else if (slot_free) begin
            if (byte_valid) begin
                bus_q <= byte_in;
                de_v  <= 1'b1;
            end else begin
                de_v  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/par_sync_tx.sv
// Parallel synchronous byte transmitter with ready/data-enable handshake.
// Does: accepts host words, unpacks them LSB first and drives one byte per
// data clock cycle, with receiver stall and polarity options.
// Assumes: host port is synchronous to pclk; cfg_* are static during traffic.
module par_sync_tx #(
    parameter int WORD_W     = 32,
    parameter int BYTE_W     = 8,
    parameter int FIFO_WORDS = 8,
    parameter bit CLK_FALL   = 1'b0
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic              wr_space,
    output logic              ovf_flag,
    input  logic              cfg_rdy_pol,
    input  logic              cfg_de_pol,
    input  logic              rdy_in,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_de
);
    logic              core_clk;
    logic [WORD_W-1:0] head_word;
    logic              fifo_empty;
    logic              fifo_full;
    logic              word_pop;
    logic [BYTE_W-1:0] next_byte;
    logic              byte_avail;
    logic              byte_take;
    logic              rdy_s;
    logic [BYTE_W-1:0] bus_q;
    logic              de_v;

    // Select which pclk edge drives the bus
    if (CLK_FALL) begin : g_fall
        assign core_clk = ~pclk;
    end else begin : g_rise
        assign core_clk = pclk;
    end

    assign wr_space = !fifo_full;
    assign bus_data = bus_q;

    ptx_word_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (FIFO_WORDS)
    ) u_fifo (
        .clk       (core_clk),
        .rst_n     (rst_n),
        .push_req  (wr_en),
        .push_word (wr_word),
        .pop       (word_pop),
        .head      (head_word),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .ovf       (ovf_flag)
    );

    ptx_byte_unpack #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_unpack (
        .clk        (core_clk),
        .rst_n      (rst_n),
        .head_word  (head_word),
        .word_valid (!fifo_empty),
        .byte_take  (byte_take),
        .byte_out   (next_byte),
        .byte_valid (byte_avail),
        .word_done  (word_pop)
    );

    ptx_ready_sample u_rdy (
        .clk     (core_clk),
        .rst_n   (rst_n),
        .rdy_pin (rdy_in),
        .pol     (cfg_rdy_pol),
        .rdy_ok  (rdy_s)
    );

    ptx_out_stage #(
        .BYTE_W (BYTE_W)
    ) u_out (
        .clk        (core_clk),
        .rst_n      (rst_n),
        .byte_valid (byte_avail),
        .byte_in    (next_byte),
        .rdy_ok     (rdy_s),
        .de_pol     (cfg_de_pol),
        .byte_take  (byte_take),
        .bus_q      (bus_q),
        .de_v       (de_v),
        .bus_de     (bus_de)
    );

endmodule

// File: rtl/par_sync_tx_chk.sv
// Property checker for par_sync_tx, attached by bind.
// Does: checks stall hold, idle hold, bus-change legality, overflow flag.
// Assumes: de_v/rdy_s are the internal active-high valid and sampled ready.
module par_sync_tx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_space,
    input logic              ovf_flag,
    input logic              de_v,
    input logic              rdy_s,
    input logic [BYTE_W-1:0] bus_q
);
    // Reset leaves the bus idle and no overflow recorded
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!de_v && !ovf_flag));

    // A stalled valid byte is re-presented unchanged and still valid
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (de_v && !rdy_s) |=> (de_v && $stable(bus_q)));

    // Idle cycles keep the previous bus value
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !de_v |-> (bus_q == $past(bus_q)));

    // A changed bus byte is always marked valid
    assert_no_hidden_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q != $past(bus_q)) |-> de_v);

    // Write into a full FIFO raises the overflow flag
    assert_overflow_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_space) |=> ovf_flag);

    // Overflow flag stays set until reset
    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

endmodule

bind par_sync_tx par_sync_tx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (core_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_space (wr_space),
    .ovf_flag (ovf_flag),
    .de_v     (de_v),
    .rdy_s    (rdy_s),
    .bus_q    (bus_q)
);

// File: tb/par_sync_tx_tb.sv
module par_sync_tx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_word;
    logic        wr_space;
    logic        ovf_flag;
    logic        cfg_rdy_pol;
    logic        cfg_de_pol;
    logic        rdy;
    logic [7:0]  bus_data;
    logic        bus_de;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    par_sync_tx u_dut (
        .pclk        (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_word     (wr_word),
        .wr_space    (wr_space),
        .ovf_flag    (ovf_flag),
        .cfg_rdy_pol (cfg_rdy_pol),
        .cfg_de_pol  (cfg_de_pol),
        .rdy_in      (rdy),
        .bus_data    (bus_data),
        .bus_de      (bus_de)
    );

    function automatic logic act(input logic lvl, input logic pol);
        return pol ? lvl : ~lvl;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    // Monitor: receiver model, pops scoreboard on each delivered byte
    logic [7:0] prev_bus;
    bit         prev_v;
    bit         prev_cons;
    always @(posedge clk) begin
        logic v;
        logic r;
        logic [7:0] e;
        #3;
        if (!rst_n) begin
            prev_bus  = 8'h00;
            prev_v    = 1'b0;
            prev_cons = 1'b0;
        end else begin
            v = act(bus_de, cfg_de_pol);
            r = act(rdy, cfg_rdy_pol);
            if (!v)
                chk(bus_data == prev_bus, "R5", "bus moved while DE inactive", bus_data, prev_bus);
            if (prev_v && !prev_cons) begin
                chk(v == 1'b1, "R4", "DE after stall", v, 1);
                chk(bus_data == prev_bus, "R4", "held byte after stall", bus_data, prev_bus);
            end
            if (v && r) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected delivered byte", bus_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(bus_data == e, "R2", "delivered byte", bus_data, e);
                end
            end
            prev_bus  = bus_data;
            prev_v    = v;
            prev_cons = v && r;
        end
    end

    // Driver: one cycle of stimulus; accepted writes go to the scoreboard
    task automatic step(input bit wr, input logic [31:0] w, input bit ready);
        @(posedge clk);
        #2;
        rdy     = cfg_rdy_pol ? ready : ~ready;
        wr_en   = wr;
        wr_word = w;
        if (wr && wr_space) begin
            for (int i = 0; i < 4; i++) exp_q.push_back(w[i*8 +: 8]);
        end
    endtask

    task automatic do_reset(input logic rp, input logic dp);
        rst_n       = 1'b0;
        cfg_rdy_pol = rp;
        cfg_de_pol  = dp;
        wr_en       = 1'b0;
        wr_word     = '0;
        rdy         = ~rp;
        repeat (3) @(posedge clk);
        #2;
        chk(bus_data == 8'h00, "R1", "bus in reset", bus_data, 0);
        chk(bus_de == ~dp, "R1", "DE inactive in reset", bus_de, ~dp);
        chk(wr_space == 1'b1, "R1", "space in reset", wr_space, 1);
        chk(ovf_flag == 1'b0, "R1", "overflow in reset", ovf_flag, 0);
        exp_q.delete();
        rst_n = 1'b1;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) step(1'b0, 32'h0, 1'b1);
        repeat (3) step(1'b0, 32'h0, 1'b1);
        #1;
        chk(exp_q.size() == 0, "R2", "all bytes delivered", exp_q.size(), 0);
        chk(act(bus_de, cfg_de_pol) == 1'b0, "R5", "DE inactive when empty", bus_de, ~cfg_de_pol);
    endtask

    task automatic random_traffic(input int cycles);
        for (int i = 0; i < cycles; i++)
            step(($urandom % 3) == 0, $urandom, ($urandom % 2) == 0);
        drain();
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int run;
        bit started;
        logic [31:0] w;
        logic [15:0] mask;

        // R1 + R3: back-to-back words with ready held (low pin = ready, R7)
        do_reset(1'b0, 1'b0);
        step(1'b1, 32'h03020100, 1'b1);
        step(1'b1, 32'h07060504, 1'b1);
        run = 0;
        started = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 32'h0, 1'b1);
            #1;
            if (act(bus_de, cfg_de_pol)) begin
                started = 1;
                run++;
            end else if (started) begin
                break;
            end
        end
        chk(run == 8, "R3", "consecutive valid cycles", run, 8);
        drain();

        // R6: single and double stalls swept around the underrun point
        for (int p = 0; p < 10; p++) begin
            for (int d = 0; d < 2; d++) begin
                mask = (d == 0) ? (16'h1 << p) : (16'h3 << p);
                w = 32'h10203040 + p * 32'h01010101 + d;
                step(1'b1, w, !mask[0]);
                for (int c = 1; c < 12; c++) step(1'b0, 32'h0, !mask[c]);
                #1;
                chk(exp_q.size() == 0, "R6", "stall near underrun lost no byte", exp_q.size(), 0);
                drain();
            end
        end

        // R9 + R10: fill with ready held off, then write once more
        for (int i = 0; i < 8; i++) step(1'b1, 32'hA0B0C000 + i, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        #1;
        chk(exp_q.size() == 32, "R9", "eight words accepted", exp_q.size(), 32);
        chk(wr_space == 1'b0, "R9", "no space when full", wr_space, 0);
        chk(ovf_flag == 1'b0, "R10", "no overflow yet", ovf_flag, 0);
        step(1'b1, 32'hDEADBEEF, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        #1;
        chk(ovf_flag == 1'b1, "R10", "overflow set", ovf_flag, 1);
        drain();
        chk(ovf_flag == 1'b1, "R10", "overflow sticky", ovf_flag, 1);
        chk(wr_space == 1'b1, "R9", "space after drain", wr_space, 1);

        random_traffic(400);

        // R7 + R8: high-active polarities, stall by low ready pin
        do_reset(1'b1, 1'b1);
        step(1'b1, 32'h44332211, 1'b0);
        repeat (4) step(1'b0, 32'h0, 1'b0);
        #1;
        chk(bus_de == 1'b1, "R8", "high DE marks valid", bus_de, 1);
        chk(bus_data == 8'h11, "R7", "low ready pin stalls", bus_data, 8'h11);
        chk(rdy == 1'b0, "R7", "ready pin level", rdy, 0);
        drain();
        chk(bus_de == 1'b0, "R8", "low DE marks idle", bus_de, 0);
        random_traffic(400);

        do_reset(1'b1, 1'b0);
        random_traffic(300);
        do_reset(1'b0, 1'b1);
        random_traffic(300);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule